// File: doc/BRIEF.md
# Paged DMA Address Translator

This block turns a device DMA bus address into a physical page address by looking it up in a table of 64-bit translation entries kept inside the block. The page size is picked at run time by a shift value, and a separate count register says how many table entries are live. A lookup takes the bus address and a read/write flag. It returns four things: the page-aligned bus address, the page address taken from the entry, an in-page offset mask and a two-bit access code. It also raises a flag when the direction of the access conflicts with the access code.

Entries are written by a companion update engine through a simple one-cycle write port. Reset empties the table, so every page denies access until software fills it. A lookup whose page number falls outside the live count returns a fixed "no access" result. Nothing signals an error in that case. Requests and responses each use a valid/ready handshake. The response comes from a register one cycle after the request is accepted.

Top module: `pdt_xlate`

## Requirements
- R1: Reset leaves the response register empty (`rsp_valid` 0, `req_ready` 1), every table entry zero, the page shift at 12 and the live count at 0.
- R2: The page number is the request address shifted right by the page shift. A lookup is in range only when the page number is strictly less than the live count. The entry read is the one at that page number.
- R3: For an in-range lookup, `rsp_iova` is the request address and `rsp_xlat` is the entry, each with its low page-shift bits forced to zero.
- R4: For an in-range lookup, `rsp_mask` equals 2^shift − 1, zero-extended to 64 bits.
- R5: For an in-range lookup, `rsp_perm` equals entry bits [1:0]. The encoding is 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R6: For an out-of-range lookup, `rsp_iova` and `rsp_xlat` are 0, `rsp_mask` is all ones, `rsp_perm` is 0 and `rsp_fault` is 0.
- R7: While the live count is 0, every lookup gives the out-of-range result of R6.
- R8: `rsp_fault` is 1 exactly when an in-range write (`req_write` 1) meets code 1, or an in-range read meets code 2. Otherwise it is 0.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. The response appears in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.
- R10: A table write takes effect at the clock edge it is sampled on. A lookup accepted on that same edge still sees the old entry, and later lookups see the new one.
- R11: `cfg_shift_we` loads the page shift. `cfg_count_we` loads the live count, and any value above the table depth (16 by default) is clamped to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift_we | input | 1 | Load strobe for the page shift |
| cfg_shift | input | 6 | New page shift (log2 of the page size) |
| cfg_count_we | input | 1 | Load strobe for the live entry count |
| cfg_count | input | 32 | New live entry count, clamped to the depth |
| tbl_wr_en | input | 1 | Entry write strobe from the update engine |
| tbl_wr_idx | input | 4 | Entry index to write |
| tbl_wr_data | input | 64 | Entry value to write |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Device bus address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_iova | output | 32 | Page-aligned bus address |
| rsp_xlat | output | 64 | Translated page address |
| rsp_mask | output | 64 | In-page offset mask |
| rsp_perm | output | 2 | Access code |
| rsp_fault | output | 1 | Direction conflicts with the access code |

## Verification
The assertions assume the consumer eventually raises `rsp_ready`. They also assume that the shift, count and table are not rewritten while a lookup they would affect is being accepted, unless that overlap is the point of the test. The one exception is the same-edge write case of R10, which the bench drives on purpose. The stimulus changes configuration only after the scoreboard queue has drained. It writes entries only between lookups, apart from that deliberate overlap. It also drives `rsp_ready` from a fixed stall pattern that never holds low for more than one cycle, so every response is eventually taken.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

endpackage

// File: rtl/pdt_table.sv
module pdt_table #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 64,
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);

  logic [ENTRY_W-1:0] ent_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic               hit;
    logic [ENTRY_W-1:0] ent_q;
    logic [ENTRY_W-1:0] ent_d;

    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      ent_d = ent_q;
      if (hit) ent_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign ent_w[g] = ent_q;
  end

  assign rd_data = ent_w[rd_idx];

endmodule

// File: rtl/pdt_lookup.sv
module pdt_lookup
  import pdt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRY_W = 64,
  parameter int SHIFT_W = 6,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_wr,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [CNT_W-1:0]   count,
  output logic [IDX_W-1:0]   tbl_idx,
  input  logic [ENTRY_W-1:0] entry,
  output logic [ADDR_W-1:0]  iova,
  output logic [ENTRY_W-1:0] xlat,
  output logic [ENTRY_W-1:0] mask,
  output perm_e              perm,
  output logic               fault
);

  logic [ADDR_W-1:0]  page_no;
  logic               in_range;
  logic [ENTRY_W-1:0] lo_mask;
  perm_e              ent_perm;

  assign page_no  = addr >> shift;
  assign in_range = page_no < ADDR_W'(count);
  assign tbl_idx  = page_no[IDX_W-1:0];
  assign lo_mask  = (ENTRY_W'(1) << shift) - ENTRY_W'(1);
  assign ent_perm = perm_e'(entry[1:0]);

  always_comb begin
    iova  = '0;
    xlat  = '0;
    mask  = '1;
    perm  = PERM_NONE;
    fault = 1'b0;
    if (in_range) begin
      iova  = addr & ~lo_mask[ADDR_W-1:0];
      xlat  = entry & ~lo_mask;
      mask  = lo_mask;
      perm  = ent_perm;
      fault = (is_wr && ent_perm == PERM_RD) || (!is_wr && ent_perm == PERM_WR);
    end
  end

endmodule

// File: rtl/pdt_rsp_reg.sv
module pdt_rsp_reg
  import pdt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRY_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  d_iova,
  input  logic [ENTRY_W-1:0] d_xlat,
  input  logic [ENTRY_W-1:0] d_mask,
  input  perm_e              d_perm,
  input  logic               d_fault,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ENTRY_W-1:0] rsp_xlat,
  output logic [ENTRY_W-1:0] rsp_mask,
  output perm_e              rsp_perm,
  output logic               rsp_fault
);

  logic               take;
  logic               vld_d, vld_q;
  logic [ADDR_W-1:0]  iova_q;
  logic [ENTRY_W-1:0] xlat_q, mask_q;
  perm_e              perm_q;
  logic               fault_q;

  assign req_ready = !vld_q || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    vld_d = vld_q;
    if (take)           vld_d = 1'b1;
    else if (rsp_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iova_q  <= '0;
      xlat_q  <= '0;
      mask_q  <= '0;
      perm_q  <= PERM_NONE;
      fault_q <= 1'b0;
    end else if (take) begin
      iova_q  <= d_iova;
      xlat_q  <= d_xlat;
      mask_q  <= d_mask;
      perm_q  <= d_perm;
      fault_q <= d_fault;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_iova  = iova_q;
  assign rsp_xlat  = xlat_q;
  assign rsp_mask  = mask_q;
  assign rsp_perm  = perm_q;
  assign rsp_fault = fault_q;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid) else $error("response dropped"); // R9
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> $stable(rsp_xlat) && $stable(rsp_iova) && $stable(rsp_perm))
    else $error("response changed under stall"); // R9
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_mask + ENTRY_W'(1))) else $error("mask not contiguous"); // R4
  AST_IOVA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_iova & rsp_mask[ADDR_W-1:0]) == '0) else $error("iova offset bits set"); // R3
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_perm == PERM_RD || rsp_perm == PERM_WR))
    else $error("fault on wrong code"); // R8
  AST_OOR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (&rsp_mask) |-> rsp_xlat == '0 && rsp_perm == PERM_NONE && !rsp_fault)
    else $error("out-of-range result not clean"); // R6

endmodule

// File: rtl/pdt_xlate.sv
module pdt_xlate
  import pdt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRY_W   = 64,
  parameter int DEPTH     = 16,
  parameter int SHIFT_W   = 6,
  parameter int DEF_SHIFT = 12,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_shift_we,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               cfg_count_we,
  input  logic [ADDR_W-1:0]  cfg_count,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_idx,
  input  logic [ENTRY_W-1:0] tbl_wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ENTRY_W-1:0] rsp_xlat,
  output logic [ENTRY_W-1:0] rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_fault
);

  logic [SHIFT_W-1:0] shift_d, shift_q;
  logic [CNT_W-1:0]   count_d, count_q;
  logic [IDX_W-1:0]   rd_idx;
  logic [ENTRY_W-1:0] rd_data;
  logic [ADDR_W-1:0]  lk_iova;
  logic [ENTRY_W-1:0] lk_xlat, lk_mask;
  perm_e              lk_perm, q_perm;
  logic               lk_fault;

  always_comb begin
    shift_d = shift_q;
    count_d = count_q;
    if (cfg_shift_we) shift_d = cfg_shift;
    if (cfg_count_we) begin
      if (cfg_count > ADDR_W'(DEPTH)) count_d = CNT_W'(DEPTH);
      else                            count_d = cfg_count[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= SHIFT_W'(DEF_SHIFT);
      count_q <= '0;
    end else begin
      shift_q <= shift_d;
      count_q <= count_d;
    end
  end

  pdt_table #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_idx  (tbl_wr_idx),
    .wr_data (tbl_wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  pdt_lookup #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .SHIFT_W(SHIFT_W),
               .CNT_W(CNT_W), .IDX_W(IDX_W)) u_lookup (
    .addr    (req_addr),
    .is_wr   (req_write),
    .shift   (shift_q),
    .count   (count_q),
    .tbl_idx (rd_idx),
    .entry   (rd_data),
    .iova    (lk_iova),
    .xlat    (lk_xlat),
    .mask    (lk_mask),
    .perm    (lk_perm),
    .fault   (lk_fault)
  );

  pdt_rsp_reg #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .d_iova    (lk_iova),
    .d_xlat    (lk_xlat),
    .d_mask    (lk_mask),
    .d_perm    (lk_perm),
    .d_fault   (lk_fault),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_iova  (rsp_iova),
    .rsp_xlat  (rsp_xlat),
    .rsp_mask  (rsp_mask),
    .rsp_perm  (q_perm),
    .rsp_fault (rsp_fault)
  );

  assign rsp_perm = q_perm;

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready) else $error("stalled while empty"); // R9
  AST_ACCEPT_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid) else $error("no response after accept"); // R9

endmodule

// File: tb/pdt_xlate_tb_top.sv
module pdt_xlate_tb_top;

  localparam int AW = 32;
  localparam int EW = 64;
  localparam int DEPTH = 16;

  typedef struct {
    logic [AW-1:0] iova;
    logic [EW-1:0] xlat;
    logic [EW-1:0] mask;
    logic [1:0]    perm;
    logic          fault;
    bit            in_rng;
    string         tag;
    int            acc_cyc;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_shift_we, cfg_count_we, tbl_wr_en;
  logic [5:0]    cfg_shift;
  logic [AW-1:0] cfg_count;
  logic [3:0]    tbl_wr_idx;
  logic [EW-1:0] tbl_wr_data;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_ready, rsp_fault;
  logic [AW-1:0] rsp_iova;
  logic [EW-1:0] rsp_xlat, rsp_mask;
  logic [1:0]    rsp_perm;

  logic [EW-1:0] shadow [DEPTH];
  int   sh_shift, sh_count;
  exp_t sb_q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   bp_mode = 0, done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pdt_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_shift_we(cfg_shift_we), .cfg_shift(cfg_shift),
    .cfg_count_we(cfg_count_we), .cfg_count(cfg_count),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_iova(rsp_iova), .rsp_xlat(rsp_xlat),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  task automatic chk(string req, string what, logic [EW-1:0] act, logic [EW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [AW-1:0] a, logic w, string tag);
    exp_t e;
    logic [AW-1:0] pg;
    logic [EW-1:0] lm, ent;
    pg = a >> sh_shift;
    lm = (64'd1 << sh_shift) - 64'd1;
    e.tag = tag;
    e.acc_cyc = cyc;
    e.in_rng = (sh_count != 0) && (pg < AW'(sh_count));
    if (e.in_rng) begin
      ent     = shadow[pg[3:0]];
      e.iova  = a & ~lm[AW-1:0];
      e.xlat  = ent & ~lm;
      e.mask  = lm;
      e.perm  = ent[1:0];
      e.fault = (w && ent[1:0] == 2'd1) || (!w && ent[1:0] == 2'd2);
    end else begin
      e.iova = '0; e.xlat = '0; e.mask = '1; e.perm = 2'd0; e.fault = 1'b0;
    end
    return e;
  endfunction

  task automatic set_shift(int s);
    @(negedge clk); cfg_shift_we = 1; cfg_shift = 6'(s);
    @(negedge clk); cfg_shift_we = 0;
    sh_shift = s;
  endtask

  task automatic set_count(int c);
    @(negedge clk); cfg_count_we = 1; cfg_count = AW'(c);
    @(negedge clk); cfg_count_we = 0;
    sh_count = (c > DEPTH) ? DEPTH : c;   // R11 clamp
  endtask

  task automatic wr_ent(int i, logic [EW-1:0] d);
    @(negedge clk); tbl_wr_en = 1; tbl_wr_idx = 4'(i); tbl_wr_data = d;
    @(negedge clk); tbl_wr_en = 0;
    shadow[i] = d;
  endtask

  task automatic lookup(logic [AW-1:0] a, logic w, string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    forever begin
      #8;
      if (req_ready) break;
      @(negedge clk);
    end
    sb_q.push_back(model(a, w, tag));
  endtask

  task automatic idle();
    @(negedge clk); req_valid = 0;
  endtask

  task automatic drain();
    idle();
    while (sb_q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    rsp_ready = 1;
    forever begin
      @(negedge clk);
      rsp_ready = bp_mode ? (cyc % 3 != 0) : 1'b1;
      #8;
      if (rst_n && rsp_valid && !rsp_ready)
        chk("R9", "req_ready under stall", {63'd0, req_ready}, 64'd0);
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb_q.size() == 0) begin
          chk("R9", "unexpected response", 64'd1, 64'd0);
        end else begin
          e = sb_q.pop_front();
          if (!bp_mode) chk("R9", {e.tag, " latency"}, 64'(cyc), 64'(e.acc_cyc + 1));
          chk(e.in_rng ? "R3" : "R6", {e.tag, " iova"}, 64'(rsp_iova), 64'(e.iova));
          chk(e.in_rng ? "R3" : "R6", {e.tag, " xlat"}, rsp_xlat, e.xlat);
          chk(e.in_rng ? "R4" : "R6", {e.tag, " mask"}, rsp_mask, e.mask);
          chk(e.in_rng ? "R5" : "R6", {e.tag, " perm"}, 64'(rsp_perm), 64'(e.perm));
          chk("R8", {e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_shift_we = 0; cfg_count_we = 0; tbl_wr_en = 0;
    cfg_shift = '0; cfg_count = '0; tbl_wr_idx = '0; tbl_wr_data = '0;
    req_valid = 0; req_addr = '0; req_write = 0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    sh_shift = 12; sh_count = 0;
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1", "req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1;

    // R7: count 0 after reset disables the table
    lookup(32'h0000_1234, 0, "R7 disabled");
    drain();

    // R1: default shift 12, entries zero after reset
    set_count(4);
    lookup(32'h0000_0abc, 0, "R1 reset entry0");
    lookup(32'h0000_3fff, 1, "R1 reset entry3");
    drain();

    wr_ent(0, 64'h0000_0001_2345_6001);
    wr_ent(1, 64'h0000_0002_3456_7ab2);
    wr_ent(2, 64'hffff_0003_0000_0fff);
    wr_ent(3, 64'h0000_0004_0000_8000);
    lookup(32'h0000_0123, 0, "R5 ro read");
    lookup(32'h0000_0456, 1, "R8 ro write");
    lookup(32'h0000_1789, 0, "R8 wo read");
    lookup(32'h0000_1001, 1, "R5 wo write");
    lookup(32'h0000_2fff, 1, "R5 rw write");
    lookup(32'h0000_3000, 0, "R2 last page");
    lookup(32'h0000_4000, 0, "R2 page==count");
    lookup(32'hffff_ffff, 1, "R2 far out");
    drain();

    // larger pages
    set_shift(16);
    lookup(32'h0002_abcd, 0, "R4 shift16 page2");
    lookup(32'h0003_ffff, 1, "R3 shift16 page3");
    lookup(32'h0004_0000, 0, "R2 shift16 oor");
    drain();

    // R11 clamp of count to depth
    set_shift(12);
    set_count(100);
    wr_ent(15, 64'h1234_5678_9abc_d003);
    lookup(32'h0000_f123, 0, "R11 idx15");
    lookup(32'h0001_0000, 0, "R11 idx16 oor");
    drain();

    // shift 0: one-byte pages
    set_shift(0);
    lookup(32'h0000_0002, 1, "R4 shift0");
    lookup(32'h0000_0010, 1, "R2 shift0 oor");
    drain();

    // R9 back-to-back under backpressure
    set_shift(12);
    bp_mode = 1;
    for (int k = 0; k < 10; k++) lookup(AW'(k * 32'h0000_1800 + 32'h37), k[0], "R9 burst");
    drain();
    bp_mode = 0;
    repeat (2) @(negedge clk);

    // R10: write and lookup on the same edge
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = 4'd1; tbl_wr_data = 64'h0000_00aa_bbbb_c003;
    req_valid = 1; req_addr = 32'h0000_1555; req_write = 1;
    #8;
    sb_q.push_back(model(32'h0000_1555, 1, "R10 same edge old"));
    shadow[1] = 64'h0000_00aa_bbbb_c003;
    @(negedge clk);
    tbl_wr_en = 0; req_valid = 0;
    lookup(32'h0000_1555, 1, "R10 after write new");
    drain();

    // R7 again: disable
    set_count(0);
    lookup(32'h0000_0000, 0, "R7 disabled again");
    drain();

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule